// File: doc/BRIEF.md
# Quad-Lane Link Framer

This block feeds the sending end of a data concentration link. On every cycle of the parallel clock it accepts one 32-bit word and splits it into four bytes, one per serial lane. Each lane turns its byte into a 10-bit 8b/10b character, so that the line stays DC balanced. Lane 0 carries bits 7:0, lane 1 bits 15:8, lane 2 bits 23:16 and lane 3 bits 31:24. The 10-bit characters go out on a registered bus, ready for an external serializer.

Every lane sends the K28.5 comma, all in the same cycle, in four situations: during an alignment period after reset, while a sync request is held, in the cycle of a one-cycle timing strobe, and whenever no valid word is offered. A word that arrives in such a cycle is dropped. The receiver uses these commas to lock its word boundaries. Each lane keeps its own running disparity, and every lane starts negative after reset.

The control is a three-state machine. ST_ALIGN is entered on reset and lasts ALIGN_CYC cycles, then moves to ST_RUN. ST_RUN moves to ST_SYNC when sync_req is high. ST_SYNC stays while sync_req is high and returns to ST_RUN in the first cycle that sync_req is low. That cycle still sends a comma, which gives one trailing comma.

Top module: `quad_lane_framer`

## Requirements
- R1: While rst_n is low, every lane outputs 10'b1010101010. After reset is released, the first ALIGN_CYC (default 8) clocked characters on every lane are commas, whatever the other inputs do (state ST_ALIGN).
- R2: In ST_RUN, when word_valid is 1 and both sync_req and time_strobe are 0, lane n carries data byte data_in[8n+7:8n]. The character appears on lane_code[10n+9:10n] after the next rising clock edge.
- R3: In a cycle with sync_req at 1, all lanes send a comma and the machine enters or stays in ST_SYNC. The first cycle after that with sync_req at 0 still sends a comma and returns the machine to ST_RUN.
- R4: In a cycle with time_strobe at 1, all lanes send a comma and the word offered in that cycle is dropped.
- R5: In a cycle with word_valid at 0, all lanes send a comma.
- R6: Every lane starts with negative running disparity. The first character after reset on each lane is the negative-disparity comma 10'b0011111010.
- R7: Every character is a valid 8b/10b code for its lane's current running disparity. Its bit order is abcdei fghj, with bit 9 = a, sent first. It has 4, 5 or 6 ones. The disparity flips exactly on 4-one and 6-one characters, and each lane tracks its disparity independently.
- R8: The comma is 10'b0011111010 when the lane's disparity is negative and 10'b1100000101 when it is positive. Either form flips that lane's disparity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 32 | Parallel word, byte n for lane n |
| word_valid | input | 1 | data_in holds a word to send |
| sync_req | input | 1 | Hold high to send commas continuously |
| time_strobe | input | 1 | One-cycle timing pulse that forces a comma |
| lane_code | output | 40 | Four 10-bit characters, lane n at bits 10n+9:10n |

## Verification
The hardest case to reach is the alternate x.7 sub-block. It is chosen only for six specific 5-bit values, and only when the disparity after the 6-bit sub-block has the matching sign. The lane's own history decides that sign, not the current byte. To reach it, the stimulus sweeps all 256 byte values on every lane twice, with an idle comma between the passes, so that each byte is met at both disparities. Random runs with mixed sync, strobe and idle cycles then shift the disparity again. A behavioural model encodes every character independently and decodes each lane by searching all data codes. It then rebuilds every 32-bit word and compares it with the input.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 10;
    localparam logic [BYTE_W-1:0] K28_5 = 8'hBC;

    typedef enum logic [1:0] {
        ST_ALIGN = 2'd0,
        ST_SYNC  = 2'd1,
        ST_RUN   = 2'd2
    } frm_state_e;

    typedef struct packed {
        logic              is_k;
        logic [BYTE_W-1:0] val;
    } lane_char_t;
endpackage

// File: rtl/lfr_ctrl.sv
module lfr_ctrl
    import lfr_pkg::*;
#(
    parameter int ALIGN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_valid,
    input  logic sync_req,
    input  logic time_strobe,
    output logic send_comma
);
    localparam int CNT_W = $clog2(ALIGN_CYC + 1);

    frm_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ALIGN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ALIGN: begin
                if (cnt_q == CNT_W'(ALIGN_CYC - 1)) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN:  if (sync_req)  state_d = ST_SYNC;
            ST_SYNC: if (!sync_req) state_d = ST_RUN;
            default: state_d = ST_ALIGN;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:  send_comma = sync_req | time_strobe | ~word_valid;
            default: send_comma = 1'b1;
        endcase
    end

    AST_ALIGN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALIGN) |-> (cnt_q < CNT_W'(ALIGN_CYC))); // R1
    AST_SYNC_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC && !sync_req) |=> (state_q == ST_RUN)); // R3
    AST_SYNC_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sync_req) |=> (state_q == ST_SYNC)); // R3
endmodule

// File: rtl/lfr_stripe.sv
module lfr_stripe
    import lfr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*BYTE_W-1:0] data_in,
    input  logic                    send_comma,
    output lane_char_t [LANES-1:0]  chars
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            chars[g].is_k = send_comma;
            chars[g].val  = send_comma ? K28_5 : data_in[g*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/lfr_enc.sv
module lfr_enc
    import lfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  lane_char_t        chr_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] COMMA_NEG = 10'b0011111010;
    localparam logic [CODE_W-1:0] COMMA_POS = 10'b1100000101;
    localparam logic [CODE_W-1:0] IDLE_RST  = 10'b1010101010;

    function automatic logic [5:0] sub6(input logic [4:0] x);
        case (x)
            5'd0:  sub6 = 6'b100111;  5'd1:  sub6 = 6'b011101;
            5'd2:  sub6 = 6'b101101;  5'd3:  sub6 = 6'b110001;
            5'd4:  sub6 = 6'b110101;  5'd5:  sub6 = 6'b101001;
            5'd6:  sub6 = 6'b011001;  5'd7:  sub6 = 6'b111000;
            5'd8:  sub6 = 6'b111001;  5'd9:  sub6 = 6'b100101;
            5'd10: sub6 = 6'b010101;  5'd11: sub6 = 6'b110100;
            5'd12: sub6 = 6'b001101;  5'd13: sub6 = 6'b101100;
            5'd14: sub6 = 6'b011100;  5'd15: sub6 = 6'b010111;
            5'd16: sub6 = 6'b011011;  5'd17: sub6 = 6'b100011;
            5'd18: sub6 = 6'b010011;  5'd19: sub6 = 6'b110010;
            5'd20: sub6 = 6'b001011;  5'd21: sub6 = 6'b101010;
            5'd22: sub6 = 6'b011010;  5'd23: sub6 = 6'b111010;
            5'd24: sub6 = 6'b110011;  5'd25: sub6 = 6'b100110;
            5'd26: sub6 = 6'b010110;  5'd27: sub6 = 6'b110110;
            5'd28: sub6 = 6'b001110;  5'd29: sub6 = 6'b101110;
            5'd30: sub6 = 6'b011110;  default: sub6 = 6'b101011;
        endcase
    endfunction

    function automatic logic [3:0] sub4(input logic [2:0] y, input logic alt);
        case (y)
            3'd0: sub4 = 4'b1011;  3'd1: sub4 = 4'b1001;
            3'd2: sub4 = 4'b0101;  3'd3: sub4 = 4'b1100;
            3'd4: sub4 = 4'b1101;  3'd5: sub4 = 4'b1010;
            3'd6: sub4 = 4'b0110;  default: sub4 = alt ? 4'b0111 : 4'b1110;
        endcase
    endfunction

    logic              rd_q, rd_d, rd_mid, unbal6, unbal4, use_alt;
    logic [4:0]        x;
    logic [2:0]        y;
    logic [5:0]        b6, s6;
    logic [3:0]        b4, s4;
    logic [CODE_W-1:0] code_d;

    always_comb begin
        x       = chr_i.val[4:0];
        y       = chr_i.val[7:5];
        b6      = sub6(x);
        unbal6  = ($countones(b6) != 3);
        s6      = (rd_q && (unbal6 || x == 5'd7)) ? ~b6 : b6;
        rd_mid  = rd_q ^ unbal6;
        use_alt = rd_mid ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
                         : (x == 5'd17 || x == 5'd18 || x == 5'd20);
        b4      = sub4(y, use_alt);
        unbal4  = ($countones(b4) != 2);
        s4      = (rd_mid && (unbal4 || y == 3'd3)) ? ~b4 : b4;
        if (chr_i.is_k) begin
            code_d = rd_q ? COMMA_POS : COMMA_NEG;
            rd_d   = ~rd_q;
        end else begin
            code_d = {s6, s4};
            rd_d   = rd_mid ^ unbal4;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= IDLE_RST;
            rd_q   <= 1'b0;
        end else begin
            code_o <= code_d;
            rd_q   <= rd_d;
        end
    end

    AST_CODE_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(code_o) >= 4 && $countones(code_o) <= 6)); // R7
    AST_RD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(code_o) == 6) |-> rd_q); // R7
    AST_RD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(code_o) == 4) |-> !rd_q); // R7
    AST_COMMA_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_i.is_k && !rd_q) |=> (code_o == COMMA_NEG)); // R8
endmodule

// File: rtl/quad_lane_framer.sv
module quad_lane_framer
    import lfr_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int ALIGN_CYC = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*BYTE_W-1:0] data_in,
    input  logic                    word_valid,
    input  logic                    sync_req,
    input  logic                    time_strobe,
    output logic [LANES*CODE_W-1:0] lane_code
);
    localparam int LAST = LANES - 1;

    logic                   send_comma;
    lane_char_t [LANES-1:0] chars;

    lfr_ctrl #(.ALIGN_CYC(ALIGN_CYC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .sync_req   (sync_req),
        .time_strobe(time_strobe),
        .send_comma (send_comma)
    );

    lfr_stripe #(.LANES(LANES)) u_stripe (
        .data_in   (data_in),
        .send_comma(send_comma),
        .chars     (chars)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_enc
        lfr_enc u_enc (
            .clk   (clk),
            .rst_n (rst_n),
            .chr_i (chars[g]),
            .code_o(lane_code[g*CODE_W +: CODE_W])
        );
    end

    AST_SYNC_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> (lane_code[CODE_W-1:0] == 10'b0011111010 ||
                      lane_code[CODE_W-1:0] == 10'b1100000101)); // R3
    AST_STROBE_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        time_strobe |=> (lane_code[LAST*CODE_W +: CODE_W] == 10'b0011111010 ||
                         lane_code[LAST*CODE_W +: CODE_W] == 10'b1100000101)); // R4
endmodule

// File: tb/test_quad_lane_framer.sv
module test_quad_lane_framer;
    localparam int LANES = 4;
    localparam int ALIGN = 8;
    localparam logic [9:0] CN = 10'b0011111010;
    localparam logic [9:0] CP = 10'b1100000101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data_in = '0;
    logic        word_valid = 1'b0, sync_req = 1'b0, time_strobe = 1'b0;
    logic [39:0] lane_code;

    int compared = 0, mismatched = 0;
    bit rd_m [LANES];
    int align_left;
    bit in_sync;
    bit first_char;

    always #4 clk = ~clk;

    quad_lane_framer #(.LANES(LANES), .ALIGN_CYC(ALIGN)) i_quad_lane_framer (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .word_valid(word_valid),
        .sync_req(sync_req), .time_strobe(time_strobe), .lane_code(lane_code));

    function automatic logic [5:0] m6(input int x);
        case (x)
            0: return 6'b100111;   1: return 6'b011101;   2: return 6'b101101;
            3: return 6'b110001;   4: return 6'b110101;   5: return 6'b101001;
            6: return 6'b011001;   7: return 6'b111000;   8: return 6'b111001;
            9: return 6'b100101;  10: return 6'b010101;  11: return 6'b110100;
           12: return 6'b001101;  13: return 6'b101100;  14: return 6'b011100;
           15: return 6'b010111;  16: return 6'b011011;  17: return 6'b100011;
           18: return 6'b010011;  19: return 6'b110010;  20: return 6'b001011;
           21: return 6'b101010;  22: return 6'b011010;  23: return 6'b111010;
           24: return 6'b110011;  25: return 6'b100110;  26: return 6'b010110;
           27: return 6'b110110;  28: return 6'b001110;  29: return 6'b101110;
           30: return 6'b011110;  default: return 6'b101011;
        endcase
    endfunction

    // behavioural encoder: data byte b (or comma if k) at disparity rd (1 = positive)
    function automatic logic [9:0] ref_enc(input int b, input bit k, input bit rd, output bit rd_o);
        int x, y, w6, w4;
        logic [5:0] s;
        logic [3:0] f;
        bit mid;
        if (k) begin
            rd_o = !rd;
            return rd ? CP : CN;
        end
        x = b % 32;
        y = b / 32;
        s = m6(x);
        w6 = $countones(s);
        if (rd && (w6 != 3 || x == 7)) s = ~s;
        mid = (w6 == 3) ? rd : !rd;
        case (y)
            0: f = 4'b1011; 1: f = 4'b1001; 2: f = 4'b0101; 3: f = 4'b1100;
            4: f = 4'b1101; 5: f = 4'b1010; 6: f = 4'b0110;
            default: begin
                if ((!mid && (x == 17 || x == 18 || x == 20)) ||
                    (mid && (x == 11 || x == 13 || x == 14)))
                    f = 4'b0111;
                else
                    f = 4'b1110;
            end
        endcase
        w4 = $countones(f);
        if (mid && (w4 != 2 || y == 3)) f = ~f;
        rd_o = (w4 == 2) ? mid : !mid;
        return {s, f};
    endfunction

    // behavioural decoder by search: 0..255 data, 256 comma, -1 invalid
    function automatic int ref_dec(input logic [9:0] c, input bit rd);
        bit dummy;
        if (c == (rd ? CP : CN)) return 256;
        for (int v = 0; v < 256; v++)
            if (ref_enc(v, 1'b0, rd, dummy) == c) return v;
        return -1;
    endfunction

    task automatic check(input string req, input string what, input logic [39:0] act, input logic [39:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        align_left = ALIGN;
        in_sync = 1'b0;
        first_char = 1'b1;
        for (int l = 0; l < LANES; l++) rd_m[l] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        word_valid = 1'b1;
        data_in = 32'h12345678;
        model_reset();
        @(negedge clk);
        for (int l = 0; l < LANES; l++)
            check("R1", "reset output", {30'b0, lane_code[l*10 +: 10]}, {30'b0, 10'b1010101010});
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // called just after a falling edge; drives, waits one rising edge, checks
    task automatic step(input logic [31:0] d, input bit v, input bit s, input bit t);
        bit comma, rd_before [LANES];
        string tag;
        logic [9:0] exp [LANES];
        logic [31:0] rebuilt;
        int dv;
        data_in = d; word_valid = v; sync_req = s; time_strobe = t;
        comma = (align_left > 0) || in_sync || s || t || !v;
        if (align_left > 0)      tag = "R1";
        else if (in_sync || s)   tag = "R3";
        else if (t)              tag = "R4";
        else if (!v)             tag = "R5";
        else                     tag = "R2";
        for (int l = 0; l < LANES; l++) begin
            rd_before[l] = rd_m[l];
            exp[l] = ref_enc(int'(d[l*8 +: 8]), comma, rd_m[l], rd_m[l]);
        end
        if (align_left > 0) align_left--;
        else in_sync = s;
        @(posedge clk);
        #1;
        rebuilt = '0;
        for (int l = 0; l < LANES; l++) begin
            check(tag, "lane code", {30'b0, lane_code[l*10 +: 10]}, {30'b0, exp[l]});
            if ($countones(lane_code[l*10 +: 10]) < 4 || $countones(lane_code[l*10 +: 10]) > 6)
                check("R7", "code weight", {30'b0, lane_code[l*10 +: 10]}, {30'b0, exp[l]});
            if (first_char)
                check("R6", "first char", {30'b0, lane_code[l*10 +: 10]}, {30'b0, CN});
            dv = ref_dec(lane_code[l*10 +: 10], rd_before[l]);
            if (comma)
                check("R8", "comma decode", 40'(dv), 40'd256);
            else
                rebuilt[l*8 +: 8] = dv[7:0];
            if (!comma && dv < 0)
                check("R7", "invalid code", {30'b0, lane_code[l*10 +: 10]}, {30'b0, exp[l]});
        end
        if (!comma) check("R2", "rebuilt word", {8'b0, rebuilt}, {8'b0, d});
        first_char = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        do_reset();
        // R1: alignment period ignores valid data, sync and strobe
        for (int i = 0; i < ALIGN + 2; i++) step($urandom, 1'b1, i == 3, i == 5);
        // R2: plain data
        for (int i = 0; i < 40; i++) step($urandom, 1'b1, 1'b0, 1'b0);
        // R3: sync burst then trailing comma
        for (int i = 0; i < 5; i++) step($urandom, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) step($urandom, 1'b1, 1'b0, 1'b0);
        // R4: strobes inside data
        for (int i = 0; i < 20; i++) step($urandom, 1'b1, 1'b0, (i % 5) == 2);
        // R5: idle cycles
        for (int i = 0; i < 8; i++) step($urandom, i[0], 1'b0, 1'b0);
        // R7: full byte sweep on every lane, twice, shifted by an idle comma
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 256; i++)
                step({8'(i + 3 + p), 8'(i + 2), 8'(i + 1 + p), 8'(i)}, 1'b1, 1'b0, 1'b0);
            step(32'h0, 1'b0, 1'b0, 1'b0);
        end
        // mixed controls
        for (int i = 0; i < 300; i++)
            step($urandom, ($urandom % 8) != 0, ($urandom % 16) == 0, ($urandom % 12) == 0);
        // R1/R6: reset in mid-run
        do_reset();
        for (int i = 0; i < ALIGN + 20; i++) step($urandom, 1'b1, 1'b0, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule